// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs one clause-22 management transaction at a time between a host and an external PHY over a two-wire management interface (MDC clock, bidirectional MDIO data). The host writes a single 32-bit command word that holds the start code, the operation, the PHY and register addresses, the turnaround code and 16 bits of data. The write launches the whole transaction. The block sends a preamble of 32 ones and then the command word on MDIO, clocked by MDC. MDC is a divided copy of the system clock.

For a read, the block releases MDIO from the turnaround onwards and shifts in the 16 bits that the PHY returns. When the transaction ends, those bits replace the low half of the command register. The host polls an idle flag until it is set. A port-enable input gates all management activity, and a sticky error flag records any command written while a transaction is still running. The host chooses the MDC divisor so that MDC stays at or below 2.5 MHz. Faster system clocks need the larger divisors.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, idle_o=1, mdc_o=0, mdio_oe_o=0, cmd_err_o=0 and cmd_rdata_o=0.
- R2: div_sel_i is captured when a command is accepted: code 0,1,2,3 gives an MDC period of 8,16,32,64 system clocks. Each period has a low half followed by a high half. Changing div_sel_i during a transaction has no effect. idle_o stays low for exactly 64 MDC periods after the accepting edge.
- R3: The MDIO frame is 32 ones followed by command bits 31 down to 0, MSB first. The command fields are: [31:30] start (01), [29:28] operation (10 read, any other value write), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data. mdio_o changes only on the clock edge where MDC falls, or when a command is accepted.
- R4: For a read, mdio_oe_o is high for the first 46 frame bits (preamble through register address) and low for the turnaround and data bits. For a write, mdio_oe_o is high for all 64 bits.
- R5: For a read, mdio_i is sampled on each of the 16 rising MDC edges of the data phase. When the transaction ends, cmd_rdata_o[15:0] holds those samples with the first one as MSB, and bits [31:16] keep their written value. A write leaves cmd_rdata_o equal to the written word.
- R6: A command written while idle_o=0 is ignored: the running frame and cmd_rdata_o are unaffected. It also sets cmd_err_o, which stays set until the next accepted command clears it.
- R7: With port_en_i low, a command write is ignored (no activity, no error). Dropping port_en_i during a transaction aborts it: on the next clock, idle_o=1, mdio_oe_o=0 and mdc_o=0.
- R8: A read from a PHY that never drives MDIO (line pulled high) returns 16'hFFFF in cmd_rdata_o[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Management port enable |
| div_sel_i | input | 2 | MDC divisor select (8/16/32/64) |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 32 | Command word to write |
| cmd_rdata_o | output | 32 | Command register, with read data in [15:0] |
| idle_o | output | 1 | No transaction in progress |
| cmd_err_o | output | 1 | Sticky flag: command written while busy |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The assertions assume that mdio_i is driven by a well-behaved PHY that changes it only at MDC falling edges. They also assume that port_en_i is either held for the whole transaction or dropped to abort it. The duty-cycle check relies on the divisor being latched at accept, so it ignores div_sel_i. The bench models the PHY with a pull-up that answers only during the data phase of reads, and changes that answer only on falling MDC. It toggles div_sel_i and fires overlapping command writes mid-frame to confirm they are ignored, and keeps port_en_i stable except in the directed abort case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    MDC_DIV8  = 2'd0,
    MDC_DIV16 = 2'd1,
    MDC_DIV32 = 2'd2,
    MDC_DIV64 = 2'd3
  } mdc_div_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned MIN_DIV_LOG2 = 3,
  parameter int unsigned NUM_SEL      = 4,
  localparam int unsigned SEL_W       = $clog2(NUM_SEL),
  localparam int unsigned CNT_W       = MIN_DIV_LOG2 + NUM_SEL - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] full_tab [NUM_SEL];
  logic [CNT_W-1:0] half_tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tab
    assign full_tab[g] = CNT_W'((1 << (MIN_DIV_LOG2 + g)) - 1);
    assign half_tab[g] = CNT_W'((1 << (MIN_DIV_LOG2 + g - 1)) - 1);
  end

  logic [CNT_W-1:0] cnt_q, full_m1, half_m1;
  logic             mdc_q;

  assign full_m1 = full_tab[sel_i];
  assign half_m1 = half_tab[sel_i];
  assign rise_o  = run_i && (cnt_q == half_m1);
  assign fall_o  = run_i && (cnt_q == full_m1);
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o) mdc_q <= 1'b1;
      if (fall_o) mdc_q <= 1'b0;
    end
  end

  // high-phase length counter for the duty check
  logic [CNT_W:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_len_q <= '0;
    else if (mdc_q) hi_len_q <= hi_len_q + 1'b1;
    else            hi_len_q <= '0;
  end

  assert_mdc_duty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_q) && $past(run_i) |-> hi_len_q == {1'b0, half_m1} + 1'b1);

  assert_mdc_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter import mdio_pkg::*; #(
  parameter int unsigned PRE_LEN     = 32,
  parameter int unsigned CMD_W       = 32,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned FRAME_LEN  = PRE_LEN + CMD_W,
  localparam int unsigned IDX_W      = $clog2(FRAME_LEN),
  localparam int unsigned REL_IDX    = FRAME_LEN - DATA_W - 2,
  localparam int unsigned SMP_IDX    = FRAME_LEN - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [FRAME_LEN-1:0] frame_w;
  logic [IDX_W-1:0]     bit_q, nxt_idx;
  logic                 active_q, mdio_q, oe_q, is_rd, last;
  logic [DATA_W-1:0]    rd_q;

  assign frame_w   = {{PRE_LEN{1'b1}}, cmd_i};
  assign is_rd     = cmd_i[CMD_W-3 -: 2] == OP_READ;
  assign nxt_idx   = bit_q + IDX_W'(1);
  assign last      = bit_q == IDX_W'(FRAME_LEN - 1);
  assign done_o    = active_q && fall_i && last;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign rd_data_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b0;
      rd_q     <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b1;
    end else if (active_q) begin
      if (rise_i && is_rd && bit_q >= IDX_W'(SMP_IDX))
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
          mdio_q   <= 1'b1;
        end else begin
          bit_q  <= nxt_idx;
          mdio_q <= frame_w[IDX_W'(FRAME_LEN - 1) - nxt_idx];
          oe_q   <= !(is_rd && nxt_idx >= IDX_W'(REL_IDX));
        end
      end
    end
  end

  assert_mdio_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_q) |-> $past(fall_i) || $past(start_i));

  assert_read_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && is_rd && bit_q >= IDX_W'(REL_IDX) |-> !oe_q);

  assert_write_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !is_rd |-> oe_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl import mdio_pkg::*; #(
  parameter int unsigned PRE_LEN      = 32,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned MIN_DIV_LOG2 = 3,
  parameter int unsigned NUM_DIV      = 4,
  localparam int unsigned CMD_W       = 6 + 2 * ADDR_W + DATA_W,
  localparam int unsigned SEL_W       = $clog2(NUM_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  output logic [CMD_W-1:0] cmd_rdata_o,
  output logic             idle_o,
  output logic             cmd_err_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic              busy_q, err_q, accept, abort, run, cmd_is_rd;
  logic [CMD_W-1:0]  cmd_q;
  logic [SEL_W-1:0]  div_q;
  logic              rise, fall, sh_done;
  logic [DATA_W-1:0] sh_rd;

  assign accept    = cmd_we_i && !busy_q && port_en_i;
  assign abort     = busy_q && !port_en_i;
  assign run       = busy_q && port_en_i;
  assign cmd_is_rd = cmd_q[CMD_W-3 -: 2] == OP_READ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cmd_q  <= '0;
      div_q  <= '0;
    end else begin
      if (cmd_we_i && busy_q) err_q <= 1'b1;
      else if (accept)        err_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_wdata_i;
        div_q  <= div_sel_i;
      end else if (abort) begin
        busy_q <= 1'b0;
      end else if (sh_done) begin
        busy_q <= 1'b0;
        if (cmd_is_rd) cmd_q[DATA_W-1:0] <= sh_rd;
      end
    end
  end

  mdio_clk_div #(
    .MIN_DIV_LOG2(MIN_DIV_LOG2),
    .NUM_SEL     (NUM_DIV)
  ) u_clk_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sel_i (div_q),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_shifter #(
    .PRE_LEN(PRE_LEN),
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W)
  ) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .abort_i  (abort),
    .cmd_i    (cmd_q),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .done_o   (sh_done),
    .rd_data_o(sh_rd)
  );

  assign cmd_rdata_o = cmd_q;
  assign idle_o      = !busy_q;
  assign cmd_err_o   = err_q;

  assert_busy_write_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && busy_q |=> cmd_err_o);

  assert_cmd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !sh_done |=> $stable(cmd_q));

  assert_disabled_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i && !busy_q |=> idle_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdio_oe_o && !mdc_o);
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        port_en = 1'b1, cmd_we = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic [31:0] cmd_wdata = '0, cmd_rdata;
  logic        idle, err, mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .div_sel_i(div_sel),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata), .cmd_rdata_o(cmd_rdata),
    .idle_o(idle), .cmd_err_o(err), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, fails = 0;

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // PHY model: pull-up, answers only in the data phase of reads
  logic [63:0] cap;
  int          ncap, nrise;
  bit          phy_present, phy_rd;
  logic [15:0] phy_resp;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;
  assign mdio_i = phy_drv ? phy_bit : 1'b1;

  always @(posedge mdc) begin
    nrise++;
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      ncap++;
    end
  end

  always @(negedge mdc) begin
    if (phy_present && phy_rd && nrise >= 48 && nrise < 64) begin
      phy_drv <= 1'b1;
      phy_bit <= phy_resp[63 - nrise];
    end else begin
      phy_drv <= 1'b0;
    end
  end

  function automatic logic [31:0] mk_cmd(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
  endfunction

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    cmd_wdata = w;
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we    = 1'b0;
  endtask

  task automatic run_txn(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d,
                         logic [1:0] div, bit present, logic [15:0] resp, bit intrude);
    logic [31:0] cmd;
    int n, hi, per;
    cmd = mk_cmd(rd, phy, rg, d);
    per = 8 << div;
    div_sel = div;
    phy_rd = rd; phy_present = present; phy_resp = resp;
    nrise = 0; ncap = 0; cap = '0;
    issue(cmd);
    div_sel = div ^ 2'd1;  // R2: must not matter mid-frame
    n = 0; hi = 0;
    while (!idle && n < 10000) begin
      n++;
      if (mdc) hi++;
      if (intrude && n == 40) begin
        cmd_wdata = ~cmd;
        cmd_we = 1'b1;
      end
      if (intrude && n == 41) cmd_we = 1'b0;
      @(negedge clk);
    end
    check_eq("R2", "busy cycles", 64'(n), 64'(64 * per));
    check_eq("R2", "mdc high cycles", 64'(hi), 64'(32 * per));
    check_eq("R3", "mdc rising edges", 64'(nrise), 64'd64);
    if (!rd) begin
      check_eq("R4", "driven bits on write", 64'(ncap), 64'd64);
      check_eq("R3", "write frame", cap, {32'hFFFF_FFFF, cmd});
      check_eq("R5", "word after write", 64'(cmd_rdata), 64'(cmd));
    end else begin
      check_eq("R4", "driven bits on read", 64'(ncap), 64'd46);
      check_eq("R3", "read frame head", 64'(cap[45:0]), 64'({32'hFFFF_FFFF, cmd[31:18]}));
      check_eq(present ? "R5" : "R8", "word after read", 64'(cmd_rdata),
               64'({cmd[31:16], present ? resp : 16'hFFFF}));
    end
    check_eq("R6", "error flag", 64'(err), 64'(intrude));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    int seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "idle", 64'(idle), 64'd1);
    check_eq("R1", "mdc", 64'(mdc), 64'd0);
    check_eq("R1", "oe", 64'(mdio_oe), 64'd0);
    check_eq("R1", "err", 64'(err), 64'd0);
    check_eq("R1", "rdata", 64'(cmd_rdata), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_txn(0, 5'h01, 5'h04, 16'h01E1, 2'd0, 1, 16'h0, 0);
    run_txn(1, 5'h00, 5'h02, 16'h1234, 2'd0, 1, 16'h0143, 0);
    run_txn(1, 5'h1F, 5'h03, 16'h0000, 2'd1, 0, 16'h0, 0);   // R8 no PHY
    run_txn(1, 5'h10, 5'h1F, 16'hFFFF, 2'd3, 1, 16'h8001, 0);
    run_txn(0, 5'h0A, 5'h00, 16'h3300, 2'd0, 1, 16'h0, 1);   // R6 write while busy
    run_txn(1, 5'h02, 5'h01, 16'h0000, 2'd0, 1, 16'h0000, 0); // R6 error cleared

    // R7 disabled port ignores commands
    snap = cmd_rdata;
    port_en = 1'b0;
    issue(mk_cmd(0, 5'h3, 5'h3, 16'hAAAA));
    begin
      int busy_seen = 0, mdc_seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (!idle) busy_seen++;
        if (mdc) mdc_seen++;
        @(negedge clk);
      end
      check_eq("R7", "busy while disabled", 64'(busy_seen), 64'd0);
      check_eq("R7", "mdc while disabled", 64'(mdc_seen), 64'd0);
    end
    check_eq("R7", "word while disabled", 64'(cmd_rdata), 64'(snap));
    check_eq("R7", "err while disabled", 64'(err), 64'd0);

    // R7 abort mid-frame
    port_en = 1'b1;
    div_sel = 2'd1;
    issue(mk_cmd(1, 5'h1, 5'h1, 16'h0));
    repeat (200) @(negedge clk);
    check_eq("R7", "busy before abort", 64'(idle), 64'd0);
    port_en = 1'b0;
    @(negedge clk);
    check_eq("R7", "idle after abort", 64'(idle), 64'd1);
    check_eq("R7", "oe after abort", 64'(mdio_oe), 64'd0);
    check_eq("R7", "mdc after abort", 64'(mdc), 64'd0);
    port_en = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      bit rd = 1'($urandom);
      run_txn(rd, 5'($urandom), 5'($urandom), 16'($urandom), 2'($urandom % 4),
              1'($urandom % 4 != 0), 16'($urandom), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule